// File: doc/BRIEF.md
# SMBus Combined-Transaction Sequencer

This block runs one complete SMBus transaction on top of a byte-level I2C master engine. The engine reports four things: that a byte slot is ready, that a bus error has occurred, that a negative acknowledge came back, and whether it still owns the bus. The sequencer answers with single-cycle requests: START, STOP, write a byte, take a read byte, and clear the flags. It also holds a level that selects "not acknowledge" for the next received byte.

A host loads a 7-bit target address, a direction flag, a command byte, a transaction kind and, for block transfers, a length. It then pulses `start_i` while the block is idle. Combined reads are built in a fixed order: the address is sent for a write, then the command, then a repeated START, then the address for a read. The not-acknowledge level is set up one byte early, so the target sees NACK on the final byte. Data moves through an index-addressed byte port. The transaction ends with a one-cycle `done_o`, a result code, and a sticky flag that tells the host the engine needs a reset.

Top module: `smbus_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy_o`, `done_o`, `reset_req_o`, `eng_nak_o` and every engine request are 0, and `result_o` is 0.
- R2: Kinds are coded as quick=0, byte=1, byte-data=2, word=3, block=4. An accepted quick or byte transaction pulses `eng_start_o` in the cycle after `start_i`. On the first ready event it writes the full address byte `{addr, rd}`. A byte write then sends the command byte as its single data byte.
- R3: An accepted byte-data, word or block transaction pulses `eng_start_o`. It then writes `{addr, 0}` on the first ready event and the command byte on the second.
- R4: For a read of kind 2 to 4, the ready event after the command pulses `eng_start_o` again (repeated START) and writes `{addr, 1}`.
- R5: On reads, `eng_nak_o` changes only on the address-for-read write and on read takes. On the address-for-read write it becomes 1 if the length is 1, and 0 otherwise. On a take it becomes 1 when two bytes remained before that take, and 0 otherwise.
- R6: Each read ready event pulses `eng_take_o` and returns `eng_rdata_i` on `rd_data_o`, with its 0-based position on `rd_idx_o`. The take of the final byte also pulses `eng_stop_o` and `done_o`, with result ok (0).
- R7: In the write phase, each ready event writes the byte `wr_byte_i` that the host presents for `data_idx_o`, in index order. Index 0 is the low byte of a word. A ready event with no bytes left pulses `eng_stop_o` and `done_o`, with result ok (0).
- R8: A negative acknowledge while busy pulses `eng_stop_o`, `eng_clr_o` and `done_o` together, with result no-device (1), and leaves `reset_req_o` at 0.
- R9: A bus error while busy, or a ready or NACK event seen while `eng_master_i` is low, ends with result I/O error (2) and sets `reset_req_o`. `reset_req_o` clears when the next transaction is accepted.
- R10: If no ready, error or NACK event arrives for TIMEOUT_CYC cycles, the transaction ends with I/O error (2) and `reset_req_o` set. Every event restarts the window.
- R11: A read of length 0 (a quick read), a block length of 0 or above MAX_BLOCK, or an unknown kind is rejected. Rejection gives `done_o` with result bad-argument (3) in the next cycle and no `eng_start_o`.
- R12: `start_i` while busy is ignored: no START request, and the running transaction finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Host request pulse, accepted only when idle |
| addr_i | input | 7 | Target address |
| rd_i | input | 1 | 1 = read, 0 = write |
| cmd_i | input | 8 | Command byte |
| kind_i | input | 3 | Transaction kind code |
| len_i | input | LEN_W | Block length (block kind only) |
| wr_byte_i | input | 8 | Host data byte for index `data_idx_o` |
| data_idx_o | output | LEN_W | Index of the next data byte |
| rd_valid_o | output | 1 | Read byte valid pulse |
| rd_data_o | output | 8 | Read byte |
| rd_idx_o | output | LEN_W | Index of the read byte |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Transaction finished pulse |
| result_o | output | 2 | 0 ok, 1 no-device, 2 I/O error, 3 bad argument |
| reset_req_o | output | 1 | Engine needs a reset (sticky) |
| eng_ready_i | input | 1 | Engine byte slot ready |
| eng_berr_i | input | 1 | Engine bus error |
| eng_nack_i | input | 1 | Engine received negative acknowledge |
| eng_master_i | input | 1 | Engine holds bus mastership |
| eng_rdata_i | input | 8 | Byte received by the engine |
| eng_start_o | output | 1 | START / repeated START request |
| eng_stop_o | output | 1 | STOP request |
| eng_wr_o | output | 1 | Byte write request |
| eng_wdata_o | output | 8 | Byte to transmit |
| eng_take_o | output | 1 | Received byte consumed |
| eng_nak_o | output | 1 | Send NACK on the next received byte |
| eng_clr_o | output | 1 | Clear stall and NACK flags |

## Verification
A corrupted state register shows up at the engine port on the very next ready event. The wrong byte leaves on `eng_wdata_o`, a START is missing or extra, or a take and STOP fire early. The bench compares the full sequence of engine requests against a list it builds itself. A wrong length count moves the not-acknowledge level or the STOP by one event. That also shows within one byte. Faults in timer or error handling appear as a wrong result code, or as a `done_o` that comes a cycle early or late relative to the timeout window.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

    typedef enum logic [2:0] {
        K_QUICK = 3'd0,
        K_BYTE  = 3'd1,
        K_BDATA = 3'd2,
        K_WORD  = 3'd3,
        K_BLOCK = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_NODEV  = 2'd1,
        RES_IOERR  = 2'd2,
        RES_BADARG = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_CMD, S_RSTART, S_QUICK, S_READ, S_WRITE
    } state_e;

    typedef struct packed {
        logic [6:0] addr;
        logic       rd;
        logic [7:0] cmd;
        kind_e      kind;
    } req_t;

    // quick and byte kinds skip the command phase
    function automatic logic short_form(kind_e k);
        return (k == K_QUICK) || (k == K_BYTE);
    endfunction

endpackage

// File: rtl/smbus_seq_decode.sv
module smbus_seq_decode
    import smbus_seq_pkg::*;
#(
    parameter int MAX_BLOCK = 32,
    parameter int LEN_W     = 6
) (
    input  logic [2:0]       kind,
    input  logic             rd,
    input  logic [LEN_W-1:0] len_req,
    output logic [LEN_W-1:0] len,
    output logic             ok
);
    always_comb begin
        case (kind_e'(kind))
            K_QUICK:         len = '0;
            K_BYTE, K_BDATA: len = LEN_W'(1);
            K_WORD:          len = LEN_W'(2);
            default:         len = len_req;
        endcase
        ok = (kind <= 3'(K_BLOCK));
        if ((kind == 3'(K_BLOCK)) &&
            ((len_req == '0) || (len_req > LEN_W'(MAX_BLOCK))))
            ok = 1'b0;
        if (rd && (len == '0))
            ok = 1'b0;
    end
endmodule

// File: rtl/smbus_seq_watch.sv
module smbus_seq_watch #(
    parameter int TIMEOUT_CYC = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic kick,
    output logic expire
);
    localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;

    logic [CW-1:0] cnt;

    assign expire = run && !kick && (cnt == CW'(TIMEOUT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || kick)
            cnt <= '0;
        else if (!expire)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/smbus_seq.sv
module smbus_seq
    import smbus_seq_pkg::*;
#(
    parameter  int MAX_BLOCK   = 32,
    parameter  int TIMEOUT_CYC = 2000,
    localparam int LEN_W       = $clog2(MAX_BLOCK + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [6:0]       addr_i,
    input  logic             rd_i,
    input  logic [7:0]       cmd_i,
    input  logic [2:0]       kind_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [7:0]       wr_byte_i,
    output logic [LEN_W-1:0] data_idx_o,
    output logic             rd_valid_o,
    output logic [7:0]       rd_data_o,
    output logic [LEN_W-1:0] rd_idx_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       result_o,
    output logic             reset_req_o,
    input  logic             eng_ready_i,
    input  logic             eng_berr_i,
    input  logic             eng_nack_i,
    input  logic             eng_master_i,
    input  logic [7:0]       eng_rdata_i,
    output logic             eng_start_o,
    output logic             eng_stop_o,
    output logic             eng_wr_o,
    output logic [7:0]       eng_wdata_o,
    output logic             eng_take_o,
    output logic             eng_nak_o,
    output logic             eng_clr_o
);
    state_e           state;
    req_t             req;
    logic [LEN_W-1:0] left, idx;
    res_e             res_q;
    logic [LEN_W-1:0] dec_len;
    logic             dec_ok, expire, evt;

    smbus_seq_decode #(.MAX_BLOCK(MAX_BLOCK), .LEN_W(LEN_W)) u_dec (
        .kind(kind_i), .rd(rd_i), .len_req(len_i), .len(dec_len), .ok(dec_ok)
    );

    assign evt = eng_ready_i | eng_berr_i | eng_nack_i;

    smbus_seq_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watch (
        .clk(clk), .rst(rst), .run(state != S_IDLE), .kick(evt), .expire(expire)
    );

    assign busy_o     = (state != S_IDLE);
    assign result_o   = res_q;
    assign data_idx_o = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            req         <= '0;
            left        <= '0;
            idx         <= '0;
            res_q       <= RES_OK;
            done_o      <= 1'b0;
            reset_req_o <= 1'b0;
            rd_valid_o  <= 1'b0;
            rd_data_o   <= '0;
            rd_idx_o    <= '0;
            eng_start_o <= 1'b0;
            eng_stop_o  <= 1'b0;
            eng_wr_o    <= 1'b0;
            eng_wdata_o <= '0;
            eng_take_o  <= 1'b0;
            eng_nak_o   <= 1'b0;
            eng_clr_o   <= 1'b0;
        end else begin
            done_o      <= 1'b0;
            rd_valid_o  <= 1'b0;
            eng_start_o <= 1'b0;
            eng_stop_o  <= 1'b0;
            eng_wr_o    <= 1'b0;
            eng_take_o  <= 1'b0;
            eng_clr_o   <= 1'b0;
            if (state == S_IDLE) begin
                if (start_i) begin
                    reset_req_o <= 1'b0;
                    if (!dec_ok) begin
                        done_o <= 1'b1;
                        res_q  <= RES_BADARG;
                    end else begin
                        req.addr    <= addr_i;
                        req.rd      <= rd_i;
                        req.cmd     <= cmd_i;
                        req.kind    <= kind_e'(kind_i);
                        left        <= dec_len;
                        idx         <= '0;
                        eng_nak_o   <= 1'b0;
                        eng_start_o <= 1'b1;
                        state       <= short_form(kind_e'(kind_i)) ? S_QUICK : S_ADDR;
                    end
                end
            end else if (expire) begin
                state       <= S_IDLE;
                done_o      <= 1'b1;
                res_q       <= RES_IOERR;
                reset_req_o <= 1'b1;
            end else if (evt) begin
                if (eng_berr_i || !eng_master_i) begin
                    state       <= S_IDLE;
                    done_o      <= 1'b1;
                    res_q       <= RES_IOERR;
                    reset_req_o <= 1'b1;
                end else if (eng_nack_i) begin
                    state      <= S_IDLE;
                    done_o     <= 1'b1;
                    res_q      <= RES_NODEV;
                    eng_stop_o <= 1'b1;
                    eng_clr_o  <= 1'b1;
                end else begin
                    case (state)
                        S_ADDR: begin
                            eng_wr_o    <= 1'b1;
                            eng_wdata_o <= {req.addr, 1'b0};
                            state       <= S_CMD;
                        end
                        S_CMD: begin
                            eng_wr_o    <= 1'b1;
                            eng_wdata_o <= req.cmd;
                            state       <= req.rd ? S_RSTART : S_WRITE;
                        end
                        S_RSTART, S_QUICK: begin
                            if (state == S_RSTART)
                                eng_start_o <= 1'b1;
                            eng_wr_o    <= 1'b1;
                            eng_wdata_o <= {req.addr, req.rd};
                            if (req.rd) begin
                                eng_nak_o <= (left == LEN_W'(1));
                                state     <= S_READ;
                            end else begin
                                state     <= S_WRITE;
                            end
                        end
                        S_READ: begin
                            eng_nak_o  <= (left == LEN_W'(2));
                            eng_take_o <= 1'b1;
                            rd_valid_o <= 1'b1;
                            rd_data_o  <= eng_rdata_i;
                            rd_idx_o   <= idx;
                            idx        <= idx + 1'b1;
                            left       <= left - 1'b1;
                            if (left == LEN_W'(1)) begin
                                eng_stop_o <= 1'b1;
                                done_o     <= 1'b1;
                                res_q      <= RES_OK;
                                state      <= S_IDLE;
                            end
                        end
                        S_WRITE: begin
                            if (left == '0) begin
                                eng_stop_o <= 1'b1;
                                done_o     <= 1'b1;
                                res_q      <= RES_OK;
                                state      <= S_IDLE;
                            end else begin
                                eng_wr_o    <= 1'b1;
                                eng_wdata_o <= (req.kind == K_BYTE) ? req.cmd : wr_byte_i;
                                idx         <= idx + 1'b1;
                                left        <= left - 1'b1;
                            end
                        end
                        default: state <= S_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/smbus_seq_chk.sv
module smbus_seq_chk
    import smbus_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic [1:0] result_o,
    input logic       reset_req_o,
    input logic       eng_ready_i,
    input logic       eng_berr_i,
    input logic       eng_nack_i,
    input logic       eng_master_i,
    input logic       eng_start_o,
    input logic       eng_stop_o,
    input logic       eng_clr_o,
    input logic       eng_wr_o,
    input logic [7:0] eng_wdata_o,
    input state_e     state
);
    // R8: NACK ends with no-device, stop and flag clear, no reset request
    a_r8_nack_nodev: assert property (@(posedge clk) disable iff (rst)
        busy_o && eng_nack_i && !eng_berr_i && eng_master_i
        |=> done_o && result_o == 2'd1 && eng_stop_o && eng_clr_o && !reset_req_o);

    // R9: bus error or lost mastership ends with I/O error and reset request
    a_r9_err_reset: assert property (@(posedge clk) disable iff (rst)
        busy_o && (eng_berr_i || (!eng_master_i && (eng_ready_i || eng_nack_i)))
        |=> done_o && result_o == 2'd2 && reset_req_o);

    // R12: a request while busy never produces a START
    a_r12_no_start_busy: assert property (@(posedge clk) disable iff (rst)
        busy_o && start_i && state != S_RSTART |=> !eng_start_o);

    // R3: the address byte in the command phase is always a write
    a_r3_addr_write: assert property (@(posedge clk) disable iff (rst)
        eng_wr_o && $past(state) == S_ADDR |-> !eng_wdata_o[0]);

    // R6: a finished transaction leaves the block idle
    a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
endmodule

bind smbus_seq smbus_seq_chk u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .reset_req_o(reset_req_o), .eng_ready_i(eng_ready_i),
    .eng_berr_i(eng_berr_i), .eng_nack_i(eng_nack_i), .eng_master_i(eng_master_i),
    .eng_start_o(eng_start_o), .eng_stop_o(eng_stop_o), .eng_clr_o(eng_clr_o),
    .eng_wr_o(eng_wr_o), .eng_wdata_o(eng_wdata_o), .state(state)
);

// File: tb/smbus_seq_bench.sv
`timescale 1ns/1ps
module smbus_seq_bench;
    localparam int TO    = 16;
    localparam int LEN_W = 6;

    logic clk = 0, rst = 1;
    always #4 clk = ~clk;

    logic start_i = 0, rd_i = 0;
    logic [6:0] addr_i = 0;
    logic [7:0] cmd_i = 0;
    logic [2:0] kind_i = 0;
    logic [LEN_W-1:0] len_i = 0;
    logic [7:0] wr_byte_i;
    logic [LEN_W-1:0] data_idx_o, rd_idx_o;
    logic rd_valid_o, busy_o, done_o, reset_req_o;
    logic [7:0] rd_data_o, eng_wdata_o;
    logic [1:0] result_o;
    logic eng_ready_i = 0, eng_berr_i = 0, eng_nack_i = 0, eng_master_i = 1;
    logic [7:0] eng_rdata_i = 8'h50;
    logic eng_start_o, eng_stop_o, eng_wr_o, eng_take_o, eng_nak_o, eng_clr_o;

    assign wr_byte_i = 8'hA0 + 8'(data_idx_o);

    smbus_seq #(.MAX_BLOCK(32), .TIMEOUT_CYC(TO)) u_smbus_seq (.*);

    int ntests = 0, nfail = 0;
    logic [7:0] wlog [0:63];
    int nwr, nst, nrd, nakerr, rderr, ndone;
    logic [LEN_W-1:0] cur_len;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [2:0] k, input logic r, input logic [LEN_W-1:0] l,
                          input logic [6:0] a, input logic [7:0] c);
        @(negedge clk);
        kind_i = k; rd_i = r; len_i = l; addr_i = a; cmd_i = c; start_i = 1;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic event_pulse(input logic r, input logic b, input logic n, input int gap);
        repeat (gap - 1) @(negedge clk);
        eng_ready_i = r; eng_berr_i = b; eng_nack_i = n;
        @(negedge clk);
        eng_ready_i = 0; eng_berr_i = 0; eng_nack_i = 0;
    endtask

    // record engine requests after one sample point; check NACK level (R5) and read data (R6)
    task automatic sample_log();
        if (eng_start_o) nst++;
        if (eng_wr_o) begin
            wlog[nwr] = eng_wdata_o;
            nwr++;
            if (rd_i && eng_wdata_o == {addr_i, 1'b1} && eng_nak_o !== (cur_len == 1)) nakerr++;
        end
        if (eng_take_o) begin
            if (eng_nak_o !== ((int'(cur_len) - nrd) == 2)) nakerr++;
            if (rd_data_o !== 8'h50 + 8'(nrd) || rd_idx_o !== LEN_W'(nrd) || !rd_valid_o) rderr++;
            nrd++;
            eng_rdata_i = 8'h50 + 8'(nrd);
        end
        if (done_o) ndone++;
    endtask

    task automatic run_txn(input logic [2:0] k, input logic r, input logic [LEN_W-1:0] l,
                           input logic [6:0] a, input logic [7:0] c, input int gap);
        nwr = 0; nst = 0; nrd = 0; nakerr = 0; rderr = 0; ndone = 0;
        eng_rdata_i = 8'h50;
        cur_len = (k == 0) ? 0 : (k <= 2) ? 1 : (k == 3) ? 2 : l;
        launch(k, r, l, a, c);
        sample_log();
        for (int e = 0; e < 80 && ndone == 0; e++) begin
            event_pulse(1, 0, 0, gap);
            sample_log();
        end
    endtask

    // stimulus vectors: {kind, rd, len, addr, cmd}
    localparam logic [24:0] VEC [8] = '{
        {3'd0, 1'b0, 6'd0, 7'h2A, 8'h00},
        {3'd1, 1'b0, 6'd0, 7'h11, 8'h5C},
        {3'd1, 1'b1, 6'd0, 7'h12, 8'h00},
        {3'd2, 1'b0, 6'd0, 7'h33, 8'h07},
        {3'd3, 1'b1, 6'd0, 7'h44, 8'h10},
        {3'd4, 1'b0, 6'd3, 7'h55, 8'h20},
        {3'd4, 1'b1, 6'd4, 7'h66, 8'h30},
        {3'd3, 1'b0, 6'd0, 7'h21, 8'h08}
    };

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 busy/done/rst_req", {busy_o, done_o, reset_req_o}, 0);
        check("R1 engine requests", {eng_start_o, eng_stop_o, eng_wr_o, eng_take_o, eng_nak_o, eng_clr_o}, 0);
        rst = 0;
        @(negedge clk);
        check("R1 after release", {busy_o, done_o, result_o, eng_start_o}, 0);

        // table walk
        for (int v = 0; v < 8; v++) begin
            logic [2:0] k; logic r; logic [5:0] l; logic [6:0] a; logic [7:0] c;
            logic [7:0] exp [0:63];
            int ne, ns, mism;
            {k, r, l, a, c} = VEC[v];
            run_txn(k, r, l, a, c, 3);
            ne = 0;
            if (k <= 1) begin
                exp[ne++] = {a, r};
                if (!r && k == 1) exp[ne++] = c;
                ns = 1;
            end else begin
                exp[ne++] = {a, 1'b0};
                exp[ne++] = c;
                if (r) exp[ne++] = {a, 1'b1};
                else for (int i = 0; i < int'(cur_len); i++) exp[ne++] = 8'hA0 + 8'(i);
                ns = r ? 2 : 1;
            end
            mism = 0;
            for (int i = 0; i < ne && i < nwr; i++) if (wlog[i] !== exp[i]) mism++;
            check(r ? "R6 read result ok" : "R7 write result ok", {ndone, result_o}, {32'(1) << 2});
            check("R2 R3 R7 write byte count", nwr, ne);
            check("R2 R3 R7 write byte order", mism, 0);
            check("R4 start count", nst, ns);
            check("R6 read count", nrd, r ? int'(cur_len) : 0);
            check("R6 read data", rderr, 0);
            check("R5 nack level", nakerr, 0);
            check("R7 no reset request", reset_req_o, 0);
        end

        // R11 rejections
        launch(3'd0, 1, 0, 7'h10, 0);
        check("R11 quick read rejected", {done_o, result_o, eng_start_o}, {1'b1, 2'd3, 1'b0});
        launch(3'd4, 0, 0, 7'h10, 0);
        check("R11 block len 0 rejected", {done_o, result_o, eng_start_o}, {1'b1, 2'd3, 1'b0});
        launch(3'd4, 1, 33, 7'h10, 0);
        check("R11 block len 33 rejected", {done_o, result_o, eng_start_o}, {1'b1, 2'd3, 1'b0});
        launch(3'd5, 0, 1, 7'h10, 0);
        check("R11 unknown kind rejected", {done_o, result_o, eng_start_o}, {1'b1, 2'd3, 1'b0});
        launch(3'd4, 1, 32, 7'h10, 0);
        check("R11 block len 32 accepted", {done_o, eng_start_o, busy_o}, 3'b011);

        // R8 NACK aborts
        event_pulse(0, 0, 1, 2);
        check("R8 nack outcome", {done_o, result_o, eng_stop_o, eng_clr_o, reset_req_o, busy_o},
              {1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0});

        // R9 bus error
        launch(3'd2, 0, 0, 7'h20, 8'h01);
        event_pulse(1, 0, 0, 2);
        event_pulse(0, 1, 0, 2);
        check("R9 bus error", {done_o, result_o, reset_req_o, busy_o}, {1'b1, 2'd2, 1'b1, 1'b0});
        // R9 lost mastership; reset request cleared on acceptance
        launch(3'd0, 0, 0, 7'h21, 0);
        check("R9 reset request cleared on accept", reset_req_o, 0);
        eng_master_i = 0;
        event_pulse(1, 0, 0, 2);
        eng_master_i = 1;
        check("R9 lost master", {done_o, result_o, reset_req_o}, {1'b1, 2'd2, 1'b1});

        // R10 timeout window
        begin
            int first;
            first = 0;
            launch(3'd0, 0, 0, 7'h22, 0);
            for (int j = 1; j <= TO + 3; j++) begin
                @(negedge clk);
                if (done_o && first == 0) first = j;
            end
            check("R10 timeout cycle", first, TO);
            check("R10 timeout outcome", {result_o, reset_req_o}, {2'd2, 1'b1});
        end
        // R10 events spaced by the full window keep the transaction alive
        run_txn(3'd3, 0, 0, 7'h23, 8'h09, TO);
        check("R10 window restart", {ndone, result_o, nwr}, {32'(1), 2'd0, 32'(4)});

        // R12 request while busy ignored
        launch(3'd0, 0, 0, 7'h24, 0);
        event_pulse(1, 0, 0, 2);
        @(negedge clk);
        kind_i = 3'd2; start_i = 1;
        @(negedge clk);
        start_i = 0;
        check("R12 start ignored while busy", {eng_start_o, busy_o, done_o}, 3'b010);
        event_pulse(1, 0, 0, 2);
        check("R12 original finishes", {done_o, result_o, eng_stop_o, eng_wr_o}, {1'b1, 2'd0, 1'b1, 1'b0});

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule